// File: doc/BRIEF.md
# Palette Host Register Port

This block sits between a host processor bus and the color palette storage of a display pipeline. The host talks to it through an 8-bit data path with active-low chip select, write strobe and read strobe, and a 2-bit command that steers each byte. The target is either the address register, the palette RAM data path or the overlay register data path. Strobes are asynchronous to the core clock. They pass through a multi-stage synchronizer, and each access takes effect when its strobe condition ends.

Colors are 24 bits wide and move as three byte cycles: red, then green, then blue. A three-state position counter tracks which byte comes next. A palette write is committed to the external RAM write port only after the blue byte arrives, and the address then steps by one. Reads work from an entry that is prefetched whenever the address changes. The overlay registers live inside the block and are exported so the pixel path can read them.

The data path is split into an input, an output and an output enable, so the pad ring forms the bidirectional pin. An access with chip select, read strobe and write strobe all low at once is reported and discarded.

Top module: `pal_host_port`

## Requirements
- R1: After reset the address register reads 0, the position counter is at red, `access_fault` is 0, `host_doe` is 0 and every overlay color is 0.
- R2: A write with command 00 or command 10 loads the address register from the data byte. A read with either of these commands returns the address register.
- R3: With command 01, three completed writes give red, green and blue in that order. After the blue byte, exactly one `pal_we` pulse carries address A and data {red[23:16], green[15:8], blue[7:0]}, where A is the address at the first byte.
- R4: Each completed three-byte data transfer, read or write, increments the address. The address wraps from 255 to 0.
- R5: A write to the address register returns the position counter to red. A partial color that was in progress is dropped.
- R6: With command 01, reads return the red, green and blue bytes of the RAM entry at the current address, in that order. The entry is prefetched after each address load or increment.
- R7: With command 11, a three-byte write to address k, where k is 1 to 3, loads overlay color k. This is slot k-1 of `ovl_colors`, 24 bits per slot with slot 0 at the bottom. Writes to any other address change no overlay color, but the address still increments.
- R8: With command 11, reads at address 1 to 3 return that overlay color's bytes in red, green, blue order. Reads at any other address return 0.
- R9: `host_doe` is 1 only while chip select and read strobe are low and the write strobe is high.
- R10: If chip select, read strobe and write strobe are all low at once, `access_fault` rises and stays high until chip select returns high. That episode makes no write, no RAM commit and no position change.
- R11: `pal_we` pulses only after a blue byte written with command 01, never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_cmd | input | 2 | Access target: 00/10 address, 01 palette, 11 overlay |
| host_din | input | 8 | Write data from the host pad |
| host_dout | output | 8 | Read data toward the host pad |
| host_doe | output | 1 | Pad output enable for the read data |
| access_fault | output | 1 | Illegal all-low strobe condition seen |
| pal_we | output | 1 | Palette RAM write enable, one cycle |
| pal_waddr | output | 8 | Palette RAM write address |
| pal_wdata | output | 24 | Palette RAM write data, red in the top byte |
| pal_raddr | output | 8 | Palette RAM read address for the prefetch |
| pal_rdata | input | 24 | Palette RAM read data, one cycle after the address |
| ovl_colors | output | 72 | Three overlay colors, slot 0 in the low 24 bits |

## Verification
The bench builds the block with its default parameters: an 8-bit address over a 256-entry palette, three overlay slots, a two-stage synchronizer and a one-cycle RAM read latency. Because the address is as wide as the data byte, a single address write can reach entry 255, so the wrap to 0 is tested directly. The three overlay slots leave addresses 0 and 5 outside the valid range, which lets the bench exercise the ignored-write and zero-read paths. A holding time of six core cycles per strobe phase covers the synchronizer, the end-of-access detection and the prefetch latency.

// File: rtl/pal_host_pkg.sv
package pal_host_pkg;

   // Host command field: bit 0 low selects the address register.
   typedef enum logic [1:0] {
      CMD_ADDR     = 2'b00,
      CMD_PAL      = 2'b01,
      CMD_ADDR_ALT = 2'b10,
      CMD_OVL      = 2'b11
   } host_cmd_e;

   // Byte position inside a 24-bit color transfer.
   typedef enum logic [1:0] {
      POS_RED = 2'd0,
      POS_GRN = 2'd1,
      POS_BLU = 2'd2
   } byte_pos_e;

   localparam int unsigned BYTES_PER_COLOR = 3;

endpackage

// File: rtl/pal_host_sync.sv
module pal_host_sync #(
   parameter int unsigned WIDTH   = 13,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pal_host_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pal_host_ovl.sv
module pal_host_ovl #(
   parameter int unsigned COLOR_W = 24,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned N_OVL   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we_i,
   input  logic [ADDR_W-1:0]          waddr_i,
   input  logic [COLOR_W-1:0]         wdata_i,
   input  logic [ADDR_W-1:0]          raddr_i,
   output logic [COLOR_W-1:0]         rdata_o,
   output logic [N_OVL*COLOR_W-1:0]   colors_o
);

   generate
      if (N_OVL < 1 || N_OVL >= (1 << ADDR_W)) begin : g_bad_novl
         $error("pal_host_ovl: N_OVL out of range for ADDR_W");
      end
   endgenerate

   logic [N_OVL-1:0][COLOR_W-1:0] regs_q;

   // Slot i answers to address i+1; address 0 selects nothing.
   for (genvar i = 0; i < N_OVL; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[i] <= '0;
         end else if (we_i && waddr_i == ADDR_W'(i + 1)) begin
            regs_q[i] <= wdata_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < N_OVL; i++) begin
         if (raddr_i == ADDR_W'(i + 1)) rdata_o = regs_q[i];
      end
   end

   assign colors_o = regs_q;

   AST_OVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(regs_q)); // R7
   AST_OVL_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && waddr_i == '0) |=> $stable(regs_q)); // R7

endmodule

// File: rtl/pal_host_seq.sv
module pal_host_seq
   import pal_host_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned RD_LAT = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_done_i,
   input  logic                  rd_done_i,
   input  host_cmd_e             cmd_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [3*DATA_W-1:0]   ram_rdata_i,
   output logic [ADDR_W-1:0]     addr_o,
   output byte_pos_e             pos_o,
   output logic                  commit_o,
   output logic                  commit_ovl_o,
   output logic [ADDR_W-1:0]     commit_addr_o,
   output logic [3*DATA_W-1:0]   commit_data_o,
   output logic [3*DATA_W-1:0]   pref_o
);

   localparam int unsigned COLOR_W = BYTES_PER_COLOR * DATA_W;

   generate
      if (RD_LAT < 1) begin : g_bad_lat
         $error("pal_host_seq: RD_LAT must be at least 1");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("pal_host_seq: ADDR_W must fit in one data byte");
      end
   endgenerate

   logic [ADDR_W-1:0]  addr_q;
   byte_pos_e          pos_q;
   logic [DATA_W-1:0]  red_q, grn_q;
   logic               fetch_q;
   logic [RD_LAT-1:0]  fetch_sr_q;
   logic [COLOR_W-1:0] pref_q;
   logic               is_addr_cmd;

   assign is_addr_cmd = (cmd_i == CMD_ADDR) || (cmd_i == CMD_ADDR_ALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q        <= '0;
         pos_q         <= POS_RED;
         red_q         <= '0;
         grn_q         <= '0;
         fetch_q       <= 1'b1;
         commit_o      <= 1'b0;
         commit_ovl_o  <= 1'b0;
         commit_addr_o <= '0;
         commit_data_o <= '0;
      end else begin
         commit_o <= 1'b0;
         fetch_q  <= 1'b0;
         if (wr_done_i) begin
            if (is_addr_cmd) begin
               addr_q  <= wdata_i[ADDR_W-1:0];
               pos_q   <= POS_RED;
               fetch_q <= 1'b1;
            end else begin
               unique case (pos_q)
                  POS_RED: begin
                     red_q <= wdata_i;
                     pos_q <= POS_GRN;
                  end
                  POS_GRN: begin
                     grn_q <= wdata_i;
                     pos_q <= POS_BLU;
                  end
                  default: begin
                     commit_o      <= 1'b1;
                     commit_ovl_o  <= (cmd_i == CMD_OVL);
                     commit_addr_o <= addr_q;
                     commit_data_o <= {red_q, grn_q, wdata_i};
                     addr_q        <= addr_q + 1'b1;
                     pos_q         <= POS_RED;
                     fetch_q       <= 1'b1;
                  end
               endcase
            end
         end else if (rd_done_i && !is_addr_cmd) begin
            unique case (pos_q)
               POS_RED: pos_q <= POS_GRN;
               POS_GRN: pos_q <= POS_BLU;
               default: begin
                  pos_q   <= POS_RED;
                  addr_q  <= addr_q + 1'b1;
                  fetch_q <= 1'b1;
               end
            endcase
         end
      end
   end

   // Delay line matching the RAM read latency before the prefetch load.
   generate
      if (RD_LAT == 1) begin : g_lat1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fetch_sr_q <= '0;
            else        fetch_sr_q <= fetch_q;
         end
      end else begin : g_latn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fetch_sr_q <= '0;
            else        fetch_sr_q <= {fetch_sr_q[RD_LAT-2:0], fetch_q};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pref_q <= '0;
      else if (fetch_sr_q[RD_LAT-1])   pref_q <= ram_rdata_i;
   end

   assign addr_o = addr_q;
   assign pos_o  = pos_q;
   assign pref_o = pref_q;

   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q != byte_pos_e'(2'd3)); // R3
   AST_COMMIT_AFTER_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(pos_q) == POS_BLU); // R11
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> addr_q == commit_addr_o + 1'b1); // R4
   AST_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done_i && is_addr_cmd) |=> pos_q == POS_RED); // R5

endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
   import pal_host_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned N_OVL       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RD_LAT      = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_cs_n,
   input  logic                          host_wr_n,
   input  logic                          host_rd_n,
   input  logic [1:0]                    host_cmd,
   input  logic [DATA_W-1:0]             host_din,
   output logic [DATA_W-1:0]             host_dout,
   output logic                          host_doe,
   output logic                          access_fault,
   output logic                          pal_we,
   output logic [ADDR_W-1:0]             pal_waddr,
   output logic [3*DATA_W-1:0]           pal_wdata,
   output logic [ADDR_W-1:0]             pal_raddr,
   input  logic [3*DATA_W-1:0]           pal_rdata,
   output logic [N_OVL*3*DATA_W-1:0]     ovl_colors
);

   localparam int unsigned COLOR_W = BYTES_PER_COLOR * DATA_W;
   localparam int unsigned SYNC_W  = 3 + 2 + DATA_W;
   localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {(2 + DATA_W){1'b0}}};

   // ---- strobe synchronizer --------------------------------------------
   logic [SYNC_W-1:0] sync_q;
   logic              cs_s, wr_s, rd_s;
   logic [1:0]        cmd_s;
   logic [DATA_W-1:0] din_s;

   pal_host_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({host_cs_n, host_wr_n, host_rd_n, host_cmd, host_din}),
      .q_o   (sync_q)
   );

   assign {cs_s, wr_s, rd_s, cmd_s, din_s} = sync_q;

   // ---- access end detection -------------------------------------------
   logic              wr_act, rd_act, ill_act;
   logic              wr_act_q, rd_act_q, poison_q;
   host_cmd_e         cmd_q;
   logic [DATA_W-1:0] din_q;
   logic              wr_done, rd_done;

   assign wr_act  = !cs_s && !wr_s &&  rd_s;
   assign rd_act  = !cs_s && !rd_s &&  wr_s;
   assign ill_act = !cs_s && !rd_s && !wr_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
         poison_q <= 1'b0;
         cmd_q    <= CMD_ADDR;
         din_q    <= '0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         poison_q <= cs_s ? 1'b0 : (poison_q || ill_act);
         if (wr_act || rd_act) cmd_q <= host_cmd_e'(cmd_s);
         if (wr_act)           din_q <= din_s;
      end
   end

   assign wr_done = wr_act_q && !wr_act && !(poison_q || ill_act);
   assign rd_done = rd_act_q && !rd_act && !(poison_q || ill_act);

   // ---- byte sequencer -------------------------------------------------
   logic [ADDR_W-1:0]  addr_q;
   byte_pos_e          pos_q;
   logic               commit, commit_ovl;
   logic [ADDR_W-1:0]  commit_addr;
   logic [COLOR_W-1:0] commit_data, pref;

   pal_host_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_done_i     (wr_done),
      .rd_done_i     (rd_done),
      .cmd_i         (cmd_q),
      .wdata_i       (din_q),
      .ram_rdata_i   (pal_rdata),
      .addr_o        (addr_q),
      .pos_o         (pos_q),
      .commit_o      (commit),
      .commit_ovl_o  (commit_ovl),
      .commit_addr_o (commit_addr),
      .commit_data_o (commit_data),
      .pref_o        (pref)
   );

   // ---- overlay bank ---------------------------------------------------
   logic [COLOR_W-1:0] ovl_rd;

   pal_host_ovl #(.COLOR_W(COLOR_W), .ADDR_W(ADDR_W), .N_OVL(N_OVL)) u_ovl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (commit && commit_ovl),
      .waddr_i  (commit_addr),
      .wdata_i  (commit_data),
      .raddr_i  (addr_q),
      .rdata_o  (ovl_rd),
      .colors_o (ovl_colors)
   );

   // ---- RAM ports ------------------------------------------------------
   assign pal_we    = commit && !commit_ovl;
   assign pal_waddr = commit_addr;
   assign pal_wdata = commit_data;
   assign pal_raddr = addr_q;

   // ---- host read path -------------------------------------------------
   logic [COLOR_W-1:0] rd_color;

   always_comb begin
      rd_color = (host_cmd == CMD_OVL) ? ovl_rd : pref;
      unique case (host_cmd)
         CMD_PAL, CMD_OVL: begin
            unique case (pos_q)
               POS_RED: host_dout = rd_color[3*DATA_W-1:2*DATA_W];
               POS_GRN: host_dout = rd_color[2*DATA_W-1:DATA_W];
               default: host_dout = rd_color[DATA_W-1:0];
            endcase
         end
         default: host_dout = DATA_W'(addr_q);
      endcase
   end

   assign host_doe     = !host_cs_n && !host_rd_n && host_wr_n;
   assign access_fault = poison_q;

   AST_FAULT_BLOCKS_END: assert property (@(posedge clk) disable iff (!rst_n)
      (poison_q && !cs_s) |=> !commit); // R10
   AST_WE_ONLY_PAL: assert property (@(posedge clk) disable iff (!rst_n)
      pal_we |-> $past(cmd_q) == CMD_PAL); // R11

endmodule

// File: tb/pal_host_port_bench.sv
module pal_host_port_bench;

   localparam int HOLD = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [1:0]  cmd = 2'b00;
   logic [7:0]  din = 8'h00;
   logic [7:0]  dout;
   logic        doe, fault, we;
   logic [7:0]  waddr, raddr;
   logic [23:0] wdata, rdata_q;
   logic [71:0] ovl;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   logic [31:0] exp_q[$];
   logic [23:0] mem [256];

   always #5 clk = ~clk;

   pal_host_port u_pal_host_port (
      .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_wr_n(wr_n),
      .host_rd_n(rd_n), .host_cmd(cmd), .host_din(din), .host_dout(dout),
      .host_doe(doe), .access_fault(fault), .pal_we(we), .pal_waddr(waddr),
      .pal_wdata(wdata), .pal_raddr(raddr), .pal_rdata(rdata_q), .ovl_colors(ovl)
   );

   function automatic logic [23:0] pat(input logic [7:0] i);
      return {i, ~i, i ^ 8'h5A};
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
   end

   // RAM model: synchronous write, one-cycle read.
   always @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata_q <= mem[raddr];
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: every palette write must match the queue head.
   always @(negedge clk) begin
      if (rst_n && we) begin
         if (exp_q.size() == 0) begin
            check("R11 unexpected write", {waddr, wdata}, 32'hFFFFFFFF);
         end else begin
            check("R3 palette commit", {waddr, wdata}, exp_q.pop_front());
         end
      end
   end

   task automatic hw(input logic [1:0] c, input logic [7:0] d);
      @(negedge clk);
      cmd = c; din = d; cs_n = 0; wr_n = 0;
      repeat (HOLD) @(negedge clk);
      wr_n = 1; cs_n = 1;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic hr(input logic [1:0] c, output logic [7:0] d, output logic oe);
      @(negedge clk);
      cmd = c; cs_n = 0; rd_n = 0;
      repeat (HOLD) @(negedge clk);
      d = dout; oe = doe;
      rd_n = 1; cs_n = 1;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic push_color(input logic [1:0] c, input logic [7:0] a, input logic [23:0] col);
      if (c == 2'b01) exp_q.push_back({a, col});
      hw(c, col[23:16]); hw(c, col[15:8]); hw(c, col[7:0]);
   endtask

   task automatic read_color(input logic [1:0] c, input string req, input logic [23:0] exp);
      logic [7:0] b; logic oe;
      hr(c, b, oe); check(req, {24'h0, b}, {24'h0, exp[23:16]});
      hr(c, b, oe); check(req, {24'h0, b}, {24'h0, exp[15:8]});
      hr(c, b, oe); check(req, {24'h0, b}, {24'h0, exp[7:0]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] b; logic oe;
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check("R1 doe", {31'h0, doe}, 0);
      check("R1 fault", {31'h0, fault}, 0);
      check("R1 ovl", {31'h0, |ovl}, 0);
      hr(2'b00, b, oe); check("R1 addr", {24'h0, b}, 0);
      check("R9 doe during read", {31'h0, oe}, 1);

      // R2 address alias
      hw(2'b00, 8'h10); hr(2'b10, b, oe); check("R2 alias read", {24'h0, b}, 8'h10);
      hw(2'b10, 8'h20); hr(2'b00, b, oe); check("R2 alias write", {24'h0, b}, 8'h20);

      // R3 palette writes, R4 increment
      hw(2'b00, 8'h10);
      push_color(2'b01, 8'h10, 24'h112233);
      push_color(2'b01, 8'h11, 24'hAABBCC);
      hr(2'b00, b, oe); check("R4 addr step", {24'h0, b}, 8'h12);

      // R5 address write drops partial color
      hw(2'b00, 8'h30); hw(2'b01, 8'h55);
      hw(2'b00, 8'h31);
      push_color(2'b01, 8'h31, 24'h010203);

      // R4 wrap
      hw(2'b00, 8'hFF);
      push_color(2'b01, 8'hFF, 24'h0F0E0D);
      hr(2'b00, b, oe); check("R4 wrap", {24'h0, b}, 8'h00);

      // R6 reads with prefetch and increment
      hw(2'b00, 8'h40);
      read_color(2'b01, "R6 entry 40", pat(8'h40));
      read_color(2'b01, "R6 entry 41", pat(8'h41));
      hw(2'b00, 8'h10);
      read_color(2'b01, "R6 written entry", 24'h112233);
      hr(2'b00, b, oe); check("R4 read step", {24'h0, b}, 8'h11);

      // R7 overlay writes
      hw(2'b00, 8'h01);
      push_color(2'b11, 8'h01, 24'hC0FFEE);
      check("R7 slot0", {8'h0, ovl[23:0]}, 24'hC0FFEE);
      hw(2'b00, 8'h00);
      push_color(2'b11, 8'h00, 24'h777777);
      check("R7 addr0 ignored", {31'h0, ovl !== {48'h0, 24'hC0FFEE}}, 0);
      hr(2'b00, b, oe); check("R7 addr still steps", {24'h0, b}, 8'h01);
      hw(2'b00, 8'h03);
      push_color(2'b11, 8'h03, 24'h123456);
      check("R7 slot2", {8'h0, ovl[71:48]}, 24'h123456);

      // R8 overlay reads
      hw(2'b00, 8'h01); read_color(2'b11, "R8 slot1", 24'hC0FFEE);
      hw(2'b00, 8'h03); read_color(2'b11, "R8 slot3", 24'h123456);
      hw(2'b00, 8'h05); read_color(2'b11, "R8 out of range", 24'h000000);

      // R9 output enable during a write and idle
      @(negedge clk); cmd = 2'b00; din = 8'h50; cs_n = 0; wr_n = 0;
      repeat (2) @(negedge clk);
      check("R9 doe during write", {31'h0, doe}, 0);
      repeat (HOLD) @(negedge clk); wr_n = 1; cs_n = 1;
      repeat (HOLD) @(negedge clk);
      check("R9 doe idle", {31'h0, doe}, 0);

      // R10 illegal all-low episode at address 50, palette command
      @(negedge clk); cmd = 2'b01; din = 8'h77; cs_n = 0; wr_n = 0; rd_n = 0;
      repeat (HOLD) @(negedge clk);
      check("R10 fault high", {31'h0, fault}, 1);
      check("R9 doe with write low", {31'h0, doe}, 0);
      cs_n = 1; wr_n = 1; rd_n = 1;
      repeat (HOLD) @(negedge clk);
      check("R10 fault clears", {31'h0, fault}, 0);
      push_color(2'b01, 8'h50, 24'h445566);
      hw(2'b00, 8'h50);
      read_color(2'b01, "R10 entry after fault", 24'h445566);

      repeat (10) @(negedge clk);
      check("R11 queue drained", exp_q.size(), 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule